// File: doc/BRIEF.md
# Pin-Triggered Program Counter Redirect

This block sits next to the program counter of a small processor core. It watches one selectable group of eight external input pins. When an enabled pin in that group makes its chosen transition, it forces the core's program counter to a programmable 9-bit target address. It is a bare jump. No return address is pushed, and no register, counter or memory word is saved or changed. The only state the block keeps for software is the program counter that was about to execute when the jump was taken, plus a snapshot of the watched pins at the moment of detection.

Software writes a configuration word. This word holds an 8-bit enable mask, an 8-bit per-pin polarity (rising or falling), a group select and the target address. The trigger is one-shot. After it fires, it stays disarmed until software re-arms it. Even then, it only becomes live once every enabled pin has returned to its inactive level. The core sees a single-cycle load strobe with the target address, issued on a cycle where the core marks an instruction boundary.

Top module: `pin_pc_redirect`

## Requirements
- R1: After reset, `pc_load_o` and `armed_o` are 0, and `stat_pc_o` and `stat_pins_o` read 0.
- R2: A configuration write whose enable mask is zero disables the block: no pin activity and no re-arm request ever produce `pc_load_o`, and `armed_o` stays 0.
- R3: Bit i of `cfg_polarity_i` selects the trigger edge of watched pin i: 1 means a low-to-high transition triggers (active level high), 0 means a high-to-low transition triggers (active level low). A change that does not match the selected edge does not trigger.
- R4: `cfg_group_i` = g watches pins `pins_i[8g+7:8g]` (bit i of the group is pin 8g+i); activity on every other group is ignored.
- R5: With `core_step_i` held high, a triggering pin change applied before rising edge E makes `pc_load_o` high in the cycle that follows edge E+2. This covers two synchronizer stages plus one detection register.
- R6: `pc_load_o` is high for exactly one cycle per event, with `pc_load_addr_o` equal to the configured target.
- R7: The load is issued only in a cycle with `core_step_i` high. If the boundary is delayed, the load waits for it. On the edge that ends the load cycle, `stat_pc_o` captures `core_pc_i` as presented in that cycle.
- R8: `stat_pins_o` receives the whole 8-bit group value seen at detection, so that pins triggering together all appear. Several pins firing in the same cycle yield one event.
- R9: After firing, further pin transitions cause no load until a re-arm request (`rearm_i` or a configuration write).
- R10: A configuration write with nonzero mask, or a re-arm, puts the block in a waiting state. `armed_o` rises on the first edge at which the synchronized pins show every enabled pin at its inactive level. If a pin is still active, `armed_o` stays 0 until the pin is released. The release takes three edges to appear, the same path as R5.
- R11: Target address 0 is valid and gives a jump to origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Asynchronous external pins, four groups of eight |
| cfg_we_i | input | 1 | Configuration write strobe; also re-arms when the mask is nonzero |
| cfg_mask_i | input | 8 | Per-pin enable mask; zero disables the block |
| cfg_polarity_i | input | 8 | Per-pin edge choice, 1 = rising |
| cfg_group_i | input | 2 | Selects which 8-pin group is watched |
| cfg_target_i | input | 9 | Redirect target address |
| rearm_i | input | 1 | Re-arm request after an event |
| core_pc_i | input | 9 | Program counter the core is about to execute |
| core_step_i | input | 1 | High on cycles that are instruction boundaries |
| pc_load_o | output | 1 | One-cycle program counter load strobe |
| pc_load_addr_o | output | 9 | Address to load into the program counter |
| stat_pc_o | output | 9 | Program counter captured at the redirect |
| stat_pins_o | output | 8 | Watched group value captured at detection |
| armed_o | output | 1 | Trigger is live |

## Verification
The assertions assume that a pin pulse lasts at least three clock cycles, so that the synchronized value settles before detection. They also assume that `core_pc_i` only changes on cycles the core itself steps. The stimulus holds every pin change for at least three edges. It also advances the modelled program counter only in cycles where `core_step_i` is high. Before each configuration write, the random runs place the enabled pins of the chosen group at their inactive level. Expected events are computed from the old and new group values, the mask and the polarity bits.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    // Trigger life cycle: disarmed, waiting for inactive pins, live, firing.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ARMED = 2'd2,
        ST_FIRE  = 2'd3
    } pcr_state_e;

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;

endmodule

// File: rtl/pcr_detect.sv
module pcr_detect #(
    parameter  int GRP_W   = 8,
    parameter  int NUM_GRP = 4,
    localparam int PIN_W   = GRP_W * NUM_GRP,
    localparam int SEL_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [GRP_W-1:0] mask_i,
    input  logic [GRP_W-1:0] pol_i,
    output logic [GRP_W-1:0] grp_o,
    output logic             hit_o,
    output logic             active_o
);

    typedef struct packed {
        logic [GRP_W-1:0] prev;
    } det_t;

    det_t det_d, det_q;

    logic [GRP_W-1:0] cur;
    logic [GRP_W-1:0] hit_vec;
    logic [GRP_W-1:0] act_vec;

    // group multiplexer
    always_comb begin
        cur = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (sel_i == SEL_W'(g)) cur = pins_i[g*GRP_W +: GRP_W];
        end
    end

    // per-pin edge match and active-level test
    for (genvar b = 0; b < GRP_W; b++) begin : g_bit
        logic rise_b, fall_b;
        assign rise_b     = cur[b] & ~det_q.prev[b];
        assign fall_b     = ~cur[b] & det_q.prev[b];
        assign hit_vec[b] = mask_i[b] & (pol_i[b] ? rise_b : fall_b);
        assign act_vec[b] = mask_i[b] & ~(cur[b] ^ pol_i[b]);
    end

    always_comb begin
        det_d      = det_q;
        det_d.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign grp_o    = cur;
    assign hit_o    = |hit_vec;
    assign active_o = |act_vec;

    // A trigger needs the watched value to have moved since last cycle.
    assert_hit_is_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (grp_o != det_q.prev));

endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
    import pcr_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int GRP_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [GRP_W-1:0] cfg_mask_i,
    input  logic [GRP_W-1:0] cfg_pol_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic [PC_W-1:0]  cfg_target_i,
    input  logic             rearm_i,
    input  logic [PC_W-1:0]  core_pc_i,
    input  logic             core_step_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic             hit_i,
    input  logic             active_i,
    output logic [GRP_W-1:0] mask_o,
    output logic [GRP_W-1:0] pol_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_load_addr_o,
    output logic [PC_W-1:0]  stat_pc_o,
    output logic [GRP_W-1:0] stat_pins_o,
    output logic             armed_o
);

    typedef struct packed {
        pcr_state_e       st;
        logic [GRP_W-1:0] mask;
        logic [GRP_W-1:0] pol;
        logic [SEL_W-1:0] sel;
        logic [PC_W-1:0]  target;
        logic [GRP_W-1:0] snap;
        logic [PC_W-1:0]  stat_pc;
        logic [GRP_W-1:0] stat_pins;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  enabled;
    logic  load;

    assign enabled = (ctrl_q.mask != '0);
    assign load    = (ctrl_q.st == ST_FIRE) && core_step_i;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (rearm_i && enabled) ctrl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (!active_i) ctrl_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit_i) begin
                    ctrl_d.st   = ST_FIRE;
                    ctrl_d.snap = grp_i;
                end
            end
            ST_FIRE: begin
                if (core_step_i) begin
                    ctrl_d.st        = ST_IDLE;
                    ctrl_d.stat_pc   = core_pc_i;
                    ctrl_d.stat_pins = ctrl_q.snap;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase

        // a configuration write replaces the setup and restarts arming
        if (cfg_we_i) begin
            ctrl_d.mask   = cfg_mask_i;
            ctrl_d.pol    = cfg_pol_i;
            ctrl_d.sel    = cfg_sel_i;
            ctrl_d.target = cfg_target_i;
            ctrl_d.st     = (cfg_mask_i != '0) ? ST_WAIT : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ctrl_q.st <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mask_o         = ctrl_q.mask;
    assign pol_o          = ctrl_q.pol;
    assign sel_o          = ctrl_q.sel;
    assign pc_load_o      = load;
    assign pc_load_addr_o = ctrl_q.target;
    assign stat_pc_o      = ctrl_q.stat_pc;
    assign stat_pins_o    = ctrl_q.stat_pins;
    assign armed_o        = (ctrl_q.st == ST_ARMED);

    assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    assert_stat_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> (stat_pc_o == $past(core_pc_i)));

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mask == '0) |-> !pc_load_o);

    assert_arm_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(!active_i));

endmodule

// File: rtl/pin_pc_redirect.sv
module pin_pc_redirect #(
    parameter  int PC_W    = 9,
    parameter  int GRP_W   = 8,
    parameter  int NUM_GRP = 4,
    localparam int PIN_W   = GRP_W * NUM_GRP,
    localparam int SEL_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             cfg_we_i,
    input  logic [GRP_W-1:0] cfg_mask_i,
    input  logic [GRP_W-1:0] cfg_polarity_i,
    input  logic [SEL_W-1:0] cfg_group_i,
    input  logic [PC_W-1:0]  cfg_target_i,
    input  logic             rearm_i,
    input  logic [PC_W-1:0]  core_pc_i,
    input  logic             core_step_i,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_load_addr_o,
    output logic [PC_W-1:0]  stat_pc_o,
    output logic [GRP_W-1:0] stat_pins_o,
    output logic             armed_o
);

    logic [PIN_W-1:0] pins_s;
    logic [GRP_W-1:0] grp;
    logic             hit;
    logic             active;
    logic [GRP_W-1:0] mask;
    logic [GRP_W-1:0] pol;
    logic [SEL_W-1:0] sel;

    pcr_sync #(.W(PIN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (pins_s)
    );

    pcr_detect #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_i   (pins_s),
        .sel_i    (sel),
        .mask_i   (mask),
        .pol_i    (pol),
        .grp_o    (grp),
        .hit_o    (hit),
        .active_o (active)
    );

    pcr_ctrl #(.PC_W(PC_W), .GRP_W(GRP_W), .SEL_W(SEL_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we_i       (cfg_we_i),
        .cfg_mask_i     (cfg_mask_i),
        .cfg_pol_i      (cfg_polarity_i),
        .cfg_sel_i      (cfg_group_i),
        .cfg_target_i   (cfg_target_i),
        .rearm_i        (rearm_i),
        .core_pc_i      (core_pc_i),
        .core_step_i    (core_step_i),
        .grp_i          (grp),
        .hit_i          (hit),
        .active_i       (active),
        .mask_o         (mask),
        .pol_o          (pol),
        .sel_o          (sel),
        .pc_load_o      (pc_load_o),
        .pc_load_addr_o (pc_load_addr_o),
        .stat_pc_o      (stat_pc_o),
        .stat_pins_o    (stat_pins_o),
        .armed_o        (armed_o)
    );

endmodule

// File: tb/pin_pc_redirect_bench.sv
module pin_pc_redirect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [7:0]  cfg_mask_i = '0;
    logic [7:0]  cfg_polarity_i = '0;
    logic [1:0]  cfg_group_i = '0;
    logic [8:0]  cfg_target_i = '0;
    logic        rearm_i = 1'b0;
    logic [8:0]  core_pc_i = '0;
    logic        core_step_i = 1'b1;
    logic        pc_load_o;
    logic [8:0]  pc_load_addr_o;
    logic [8:0]  stat_pc_o;
    logic [7:0]  stat_pins_o;
    logic        armed_o;

    int n_chk = 0;
    int n_fail = 0;
    int load_cnt = 0;

    always #2 clk = ~clk;

    pin_pc_redirect u_pin_pc_redirect (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cfg_we_i(cfg_we_i),
        .cfg_mask_i(cfg_mask_i), .cfg_polarity_i(cfg_polarity_i),
        .cfg_group_i(cfg_group_i), .cfg_target_i(cfg_target_i),
        .rearm_i(rearm_i), .core_pc_i(core_pc_i), .core_step_i(core_step_i),
        .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o),
        .stat_pc_o(stat_pc_o), .stat_pins_o(stat_pins_o), .armed_o(armed_o)
    );

    always @(posedge clk) if (pc_load_o) load_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock: the core model advances after the edge, outputs are read 2 ns after it
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (core_step_i) core_pc_i = core_pc_i + 9'd1;
            #1;
        end
    endtask

    task automatic setg(input int g, input logic [7:0] v);
        pins_i[g*8 +: 8] = v;
    endtask

    task automatic cfg(input logic [7:0] m, input logic [7:0] p, input logic [1:0] g,
                       input logic [8:0] t);
        cfg_mask_i = m; cfg_polarity_i = p; cfg_group_i = g; cfg_target_i = t;
        cfg_we_i = 1'b1;
        tick();
        cfg_we_i = 1'b0;
    endtask

    task automatic rearm();
        rearm_i = 1'b1;
        tick();
        rearm_i = 1'b0;
    endtask

    function automatic logic exp_hit(input logic [7:0] o, input logic [7:0] n,
                                     input logic [7:0] m, input logic [7:0] p);
        for (int i = 0; i < 8; i++)
            if (m[i] && (p[i] ? (!o[i] && n[i]) : (o[i] && !n[i]))) return 1'b1;
        return 1'b0;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] rec;
        int base;
        void'($urandom(32'h5EED1234));
        tick(2);
        // R1 reset state
        chk("R1 load", pc_load_o, 0);
        chk("R1 armed", armed_o, 0);
        chk("R1 stat_pc", stat_pc_o, 0);
        chk("R1 stat_pins", stat_pins_o, 0);
        rst_n = 1'b1;
        tick(2);

        // R5/R6/R7/R8 rising pin 0 of group 0
        cfg(8'h01, 8'h01, 2'd0, 9'h155);
        tick();
        chk("R10 armed after idle config", armed_o, 1);
        setg(0, 8'h01);
        tick(2);
        chk("R5 no load before latency", pc_load_o, 0);
        tick();
        chk("R5 load at latency", pc_load_o, 1);
        chk("R6 target", pc_load_addr_o, 9'h155);
        rec = core_pc_i;
        tick();
        chk("R6 single cycle", pc_load_o, 0);
        chk("R7 captured pc", stat_pc_o, rec);
        chk("R8 snapshot", stat_pins_o, 8'h01);

        // R9 one-shot
        base = load_cnt;
        setg(0, 8'h00); tick(4);
        setg(0, 8'h01); tick(6);
        chk("R9 no refire", load_cnt - base, 0);

        // R10 re-arm with the pin still active
        rearm();
        tick(5);
        chk("R10 held active stays disarmed", armed_o, 0);
        setg(0, 8'h00);
        tick(2);
        chk("R10 not armed before sync", armed_o, 0);
        tick();
        chk("R10 armed after release", armed_o, 1);

        // R3/R11 falling edge on group 1, target 0
        setg(1, 8'hFF); tick(3);
        cfg(8'h80, 8'h00, 2'd1, 9'h000);
        tick();
        chk("R3 armed falling", armed_o, 1);
        setg(1, 8'h7F);
        tick(3);
        chk("R3 falling fires", pc_load_o, 1);
        chk("R11 jump to origin", pc_load_addr_o, 0);
        tick();
        chk("R8 falling snapshot", stat_pins_o, 8'h7F);

        // R4 group isolation, R8 simultaneous pins
        cfg(8'hFF, 8'hFF, 2'd2, 9'h1AB);
        tick();
        base = load_cnt;
        setg(0, 8'hAA); setg(1, 8'h00); setg(3, 8'hFF);
        tick(6);
        chk("R4 other groups ignored", load_cnt - base, 0);
        chk("R4 still armed", armed_o, 1);
        setg(2, 8'h05);
        tick(3);
        chk("R8 one event", pc_load_o, 1);
        tick();
        chk("R8 both pins in snapshot", stat_pins_o, 8'h05);
        chk("R6 single cycle multi", pc_load_o, 0);

        // R7 load waits for instruction boundary
        cfg(8'h01, 8'h01, 2'd0, 9'h0F0);
        tick();
        core_step_i = 1'b0;
        setg(0, 8'hAB);
        tick(6);
        chk("R7 held without boundary", pc_load_o, 0);
        rec = core_pc_i;
        core_step_i = 1'b1;
        #1;
        chk("R7 load on boundary", pc_load_o, 1);
        chk("R7 target on boundary", pc_load_addr_o, 9'h0F0);
        tick();
        chk("R7 stalled captured pc", stat_pc_o, rec);
        chk("R7 single cycle", pc_load_o, 0);

        // R2 zero mask disables
        cfg(8'h00, 8'hFF, 2'd0, 9'h1FF);
        base = load_cnt;
        setg(0, 8'h00); tick(4);
        setg(0, 8'hFF); tick(4);
        rearm();
        tick(3);
        chk("R2 no load when disabled", load_cnt - base, 0);
        chk("R2 never armed", armed_o, 0);

        // random configurations and transitions
        for (int it = 0; it < 40; it++) begin
            logic [1:0] g;
            logic [7:0] m, p, o, nv;
            logic [8:0] t;
            logic ex;
            g = 2'($urandom % 4);
            m = 8'($urandom); if (m == 0) m = 8'h01;
            p = 8'($urandom);
            t = 9'($urandom);
            o = (8'($urandom) & ~m) | (~p & m);
            setg(g, o);
            tick(3);
            cfg(m, p, g, t);
            tick();
            chk("R10 random armed", armed_o, 1);
            for (int k = 0; k < 4; k++) if (k != g) setg(k, 8'($urandom));
            nv = 8'($urandom);
            setg(g, nv);
            ex = exp_hit(o, nv, m, p);
            tick(3);
            chk("R3 R4 random trigger", pc_load_o, ex);
            if (ex) chk("R6 random target", pc_load_addr_o, t);
            tick();
            if (ex) chk("R8 random snapshot", stat_pins_o, nv);
            chk("R6 random single", pc_load_o, 0);
        end

        summary();
        $finish;
    end

endmodule